// File: doc/BRIEF.md
# Pipelined Fractional Complex Multiplier

This block multiplies two complex operands, X and Y, whose real and imaginary parts are signed fractions of `DW` bits (sign in the top bit). Each operand port has its own input register with an active-low load enable, and each port has a conjugate control that negates that operand's imaginary part. Four partial products are formed in parallel. A subtractor and an adder combine them into a full-width real and imaginary result. A common scaling shifter, an optional bias-free rounding step and an unregistered output selector follow. The selector decides which `DW`-bit slices of the two full-width results appear on the two output ports.

A new product may start on every clock. The result of an operand pair appears two clocks after the edge that captured it. The scale code and the rounding control travel down the pipeline with the data. The one product that a fractional multiplier cannot represent, minus one times minus one, is replaced by the largest positive fraction. An overflow flag reports a left shift that has pushed significant bits out of the result.

Top module: `cplx_frac_mult`

## Requirements
- R1: On a rising edge with `x_ld_n` low, the X register captures `xr_i`, `xi_i` and `x_conj`. With `x_ld_n` high it holds all three. `y_ld_n` does the same for the Y port.
- R2: Each partial product is the signed product of its two register values, kept as 2*DW-1 bits. Real = XR*YR − XI*YI and imaginary = XR*YI + XI*YR, both 2*DW bits wide.
- R3: When both operands of a partial product are the most negative value, that product becomes the largest positive 2*DW-1 bit fraction (0 sign, all other bits 1).
- R4: A captured X conjugate flag negates every product that uses XI. A captured Y conjugate flag negates every product that uses YI.
- R5: `shift_code` scales both results the same way. 2'b11 shifts left one place with zero fill. 2'b00 leaves the value unchanged. 2'b01 shifts right one place and 2'b10 shifts right two places, both arithmetic.
- R6: `ovf_o` is high exactly when code 2'b11 was applied and the real or imaginary sum had its two top bits different. With any other code it is low.
- R7: With `round_en` high, bit DW-1 of each scaled result is forced to 1 and all other bits are left unchanged.
- R8: `out_sel` is combinational and maps as follows, with MS = upper DW bits and LS = lower DW bits. 2'b00: `pr_o`=real MS, `pi_o`=imag MS. 2'b01: real LS and imag LS. 2'b10: real MS and real LS. 2'b11: imag MS and imag LS.
- R9: Operands captured at edge e, together with the `shift_code` and `round_en` sampled at edge e, produce the outputs seen after edge e+2. One operation can be issued on every clock.
- R10: A synchronous low `rst_n` clears every register, so all outputs read zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| x_ld_n | input | 1 | Load enable of the X register, active low |
| y_ld_n | input | 1 | Load enable of the Y register, active low |
| x_conj | input | 1 | Negate the imaginary part of X |
| y_conj | input | 1 | Negate the imaginary part of Y |
| xr_i | input | DW | Real part of X |
| xi_i | input | DW | Imaginary part of X |
| yr_i | input | DW | Real part of Y |
| yi_i | input | DW | Imaginary part of Y |
| shift_code | input | 2 | Result scaling code |
| round_en | input | 1 | Force the rounding bit |
| out_sel | input | 2 | Output slice selection, unregistered |
| pr_o | output | DW | First output word |
| pi_o | output | DW | Second output word |
| ovf_o | output | 1 | Left-shift overflow flag |

## Verification
The bench builds the block with its default DW of 16. At this width a 64-bit signed integer reference holds every partial product and sum exactly. That makes the minus-one trap, the full-scale sums that overflow under a left shift, and the sign fill of right shifts directly comparable. Edge operands are drawn often enough that these corners also occur in the random phase, not only in the directed opening.

// File: rtl/cfm_pkg.sv
package cfm_pkg;

  typedef enum logic [1:0] {
    SH_NONE   = 2'b00,
    SH_RIGHT1 = 2'b01,
    SH_RIGHT2 = 2'b10,
    SH_LEFT1  = 2'b11
  } shift_e;

  typedef enum logic [1:0] {
    SEL_HIGH_PAIR = 2'b00,
    SEL_LOW_PAIR  = 2'b01,
    SEL_REAL_FULL = 2'b10,
    SEL_IMAG_FULL = 2'b11
  } osel_e;

  localparam int unsigned NUM_PP = 4;
  localparam int unsigned PP_RR  = 0;
  localparam int unsigned PP_RI  = 1;
  localparam int unsigned PP_IR  = 2;
  localparam int unsigned PP_II  = 3;

endpackage

// File: rtl/cfm_port_reg.sv
module cfm_port_reg #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_n,
  input  logic [DW-1:0] re_d,
  input  logic [DW-1:0] im_d,
  input  logic          conj_d,
  output logic [DW-1:0] re_q,
  output logic [DW-1:0] im_q,
  output logic          conj_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      re_q   <= '0;
      im_q   <= '0;
      conj_q <= 1'b0;
    end else if (!ld_n) begin
      re_q   <= re_d;
      im_q   <= im_d;
      conj_q <= conj_d;
    end
  end

  // R1
  hold_when_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && ld_n) |=> ($stable(re_q) && $stable(im_q) && $stable(conj_q)));

endmodule

// File: rtl/cfm_partial_products.sv
module cfm_partial_products
  import cfm_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [DW-1:0]                xr,
  input  logic [DW-1:0]                xi,
  input  logic [DW-1:0]                yr,
  input  logic [DW-1:0]                yi,
  input  logic                         cx,
  input  logic                         cy,
  output logic [NUM_PP-1:0][2*DW-2:0]  pp_q
);

  localparam int PW = 2*DW - 1;
  localparam int FW = 2*DW;
  localparam logic [DW-1:0] NEG_ONE = {1'b1, {(DW-1){1'b0}}};
  localparam logic [PW-1:0] POS_MAX = {1'b0, {(PW-1){1'b1}}};
  localparam logic [PW-1:0] PP_MIN  = {1'b1, {(PW-1){1'b0}}};

  // Signed fraction product with the duplicated sign dropped; -1 * -1 saturates.
  function automatic logic [PW-1:0] frac_mul(input logic [DW-1:0] a, input logic [DW-1:0] b);
    logic signed [FW-1:0] full;
    full = $signed({{DW{a[DW-1]}}, a}) * $signed({{DW{b[DW-1]}}, b});
    if (a == NEG_ONE && b == NEG_ONE) return POS_MAX;
    return full[PW-1:0];
  endfunction

  logic [NUM_PP-1:0] trap_hit;
  logic [NUM_PP-1:0] neg_sel;

  for (genvar k = 0; k < NUM_PP; k++) begin : g_mul
    localparam bit A_IMAG = (k >= 2);
    localparam bit B_IMAG = ((k % 2) == 1);
    logic [DW-1:0] op_a;
    logic [DW-1:0] op_b;
    logic [PW-1:0] prod;
    logic [PW-1:0] prod_signed;

    assign op_a        = A_IMAG ? xi : xr;
    assign op_b        = B_IMAG ? yi : yr;
    assign trap_hit[k] = (op_a == NEG_ONE) && (op_b == NEG_ONE);
    assign neg_sel[k]  = (A_IMAG && cx) ^ (B_IMAG && cy);
    assign prod        = frac_mul(op_a, op_b);
    assign prod_signed = neg_sel[k] ? (~prod + 1'b1) : prod;

    always_ff @(posedge clk) begin
      if (!rst_n) pp_q[k] <= '0;
      else        pp_q[k] <= prod_signed;
    end

    // R3
    trap_to_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_n && trap_hit[k] && !neg_sel[k]) |=> (pp_q[k] == POS_MAX));

    // R3
    no_most_negative_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pp_q[k] != PP_MIN);
  end

endmodule

// File: rtl/cfm_combine.sv
module cfm_combine
  import cfm_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_PP-1:0][2*DW-2:0]  pp,
  input  shift_e                       sh,
  input  logic                         rnd,
  output logic [2*DW-1:0]              res_re,
  output logic [2*DW-1:0]              res_im,
  output logic                         ovf_q
);

  localparam int PW = 2*DW - 1;
  localparam int RW = 2*DW;

  function automatic logic [RW-1:0] widen(input logic [PW-1:0] p);
    return {p[PW-1], p};
  endfunction

  function automatic logic [RW-1:0] scale(input logic [RW-1:0] v, input shift_e code);
    case (code)
      SH_LEFT1:  return {v[RW-2:0], 1'b0};
      SH_RIGHT1: return {v[RW-1], v[RW-1:1]};
      SH_RIGHT2: return {{2{v[RW-1]}}, v[RW-1:2]};
      default:   return v;
    endcase
  endfunction

  function automatic logic apply_round(input logic [RW-1:0] v, input logic en, input int pos);
    return en ? 1'b1 : v[pos];
  endfunction

  logic [RW-1:0] sum_re, sum_im;
  logic [RW-1:0] scl_re, scl_im;
  logic [RW-1:0] fin_re, fin_im;
  logic          wide_re, wide_im;
  logic          ovf_now;

  assign sum_re  = widen(pp[PP_RR]) - widen(pp[PP_II]);
  assign sum_im  = widen(pp[PP_RI]) + widen(pp[PP_IR]);
  assign wide_re = sum_re[RW-1] ^ sum_re[RW-2];
  assign wide_im = sum_im[RW-1] ^ sum_im[RW-2];
  assign ovf_now = (sh == SH_LEFT1) && (wide_re || wide_im);
  assign scl_re  = scale(sum_re, sh);
  assign scl_im  = scale(sum_im, sh);

  always_comb begin
    fin_re = scl_re;
    fin_im = scl_im;
    fin_re[DW-1] = apply_round(scl_re, rnd, DW-1);
    fin_im[DW-1] = apply_round(scl_im, rnd, DW-1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_re <= '0;
      res_im <= '0;
      ovf_q  <= 1'b0;
    end else begin
      res_re <= fin_re;
      res_im <= fin_im;
      ovf_q  <= ovf_now;
    end
  end

  // R6
  no_ovf_without_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && sh != SH_LEFT1) |=> !ovf_q);

  // R7
  round_bit_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && rnd) |=> (res_re[DW-1] && res_im[DW-1]));

endmodule

// File: rtl/cplx_frac_mult.sv
module cplx_frac_mult
  import cfm_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          x_ld_n,
  input  logic          y_ld_n,
  input  logic          x_conj,
  input  logic          y_conj,
  input  logic [DW-1:0] xr_i,
  input  logic [DW-1:0] xi_i,
  input  logic [DW-1:0] yr_i,
  input  logic [DW-1:0] yi_i,
  input  logic [1:0]    shift_code,
  input  logic          round_en,
  input  logic [1:0]    out_sel,
  output logic [DW-1:0] pr_o,
  output logic [DW-1:0] pi_o,
  output logic          ovf_o
);

  localparam int RW = 2*DW;

  logic [DW-1:0] xr_q, xi_q, yr_q, yi_q;
  logic          cx_q, cy_q;
  logic [NUM_PP-1:0][2*DW-2:0] pp;
  logic [RW-1:0] res_re, res_im;
  shift_e        sh_s1, sh_s2;
  logic          rnd_s1, rnd_s2;

  cfm_port_reg #(.DW(DW)) u_xreg (
    .clk(clk), .rst_n(rst_n), .ld_n(x_ld_n),
    .re_d(xr_i), .im_d(xi_i), .conj_d(x_conj),
    .re_q(xr_q), .im_q(xi_q), .conj_q(cx_q)
  );

  cfm_port_reg #(.DW(DW)) u_yreg (
    .clk(clk), .rst_n(rst_n), .ld_n(y_ld_n),
    .re_d(yr_i), .im_d(yi_i), .conj_d(y_conj),
    .re_q(yr_q), .im_q(yi_q), .conj_q(cy_q)
  );

  // Scale and round controls follow their operands through both stages.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_s1  <= SH_NONE;
      sh_s2  <= SH_NONE;
      rnd_s1 <= 1'b0;
      rnd_s2 <= 1'b0;
    end else begin
      sh_s1  <= shift_e'(shift_code);
      sh_s2  <= sh_s1;
      rnd_s1 <= round_en;
      rnd_s2 <= rnd_s1;
    end
  end

  cfm_partial_products #(.DW(DW)) u_pp (
    .clk(clk), .rst_n(rst_n),
    .xr(xr_q), .xi(xi_q), .yr(yr_q), .yi(yi_q),
    .cx(cx_q), .cy(cy_q), .pp_q(pp)
  );

  cfm_combine #(.DW(DW)) u_comb (
    .clk(clk), .rst_n(rst_n), .pp(pp), .sh(sh_s2), .rnd(rnd_s2),
    .res_re(res_re), .res_im(res_im), .ovf_q(ovf_o)
  );

  function automatic logic [2*DW-1:0] pick(input osel_e sel, input logic [RW-1:0] re,
                                           input logic [RW-1:0] im);
    case (sel)
      SEL_HIGH_PAIR: return {re[RW-1:DW], im[RW-1:DW]};
      SEL_LOW_PAIR:  return {re[DW-1:0],  im[DW-1:0]};
      SEL_REAL_FULL: return re;
      default:       return im;
    endcase
  endfunction

  logic [2*DW-1:0] out_word;
  assign out_word = pick(osel_e'(out_sel), res_re, res_im);
  assign pr_o     = out_word[2*DW-1:DW];
  assign pi_o     = out_word[DW-1:0];

  // R6
  ovf_only_on_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |-> (sh_s2 == SH_LEFT1 || $past(sh_s2) == SH_LEFT1));

endmodule

// File: tb/cplx_frac_mult_bench.sv
module cplx_frac_mult_bench;

  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic x_ld_n = 1'b0, y_ld_n = 1'b0, x_conj = 1'b0, y_conj = 1'b0;
  logic [W-1:0] xr = '0, xi = '0, yr = '0, yi = '0;
  logic [1:0] shift_code = 2'b00, out_sel = 2'b00;
  logic round_en = 1'b0;
  logic [W-1:0] pr, pi;
  logic ovf;

  always #(CLK_PERIOD/2) clk = ~clk;

  cplx_frac_mult #(.DW(W)) u_cplx_frac_mult (
    .clk(clk), .rst_n(rst_n), .x_ld_n(x_ld_n), .y_ld_n(y_ld_n),
    .x_conj(x_conj), .y_conj(y_conj), .xr_i(xr), .xi_i(xi), .yr_i(yr), .yi_i(yi),
    .shift_code(shift_code), .round_en(round_en), .out_sel(out_sel),
    .pr_o(pr), .pi_o(pi), .ovf_o(ovf)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  // Reference state, following the requirements only.
  int     m_xr = 0, m_xi = 0, m_yr = 0, m_yi = 0;
  bit     m_cx = 0, m_cy = 0;
  longint m_rr = 0, m_ri = 0, m_ir = 0, m_ii = 0;
  logic [1:0] m_sh1 = 0, m_sh2 = 0;
  bit     m_rd1 = 0, m_rd2 = 0;
  logic [31:0] m_re = 0, m_im = 0;
  bit     m_ovf = 0;
  string  t1 = "R10", t2 = "R10", t3 = "R10";

  function automatic longint fmul(int a, int b);
    if (a == -32768 && b == -32768) return (longint'(1) <<< 30) - 1;
    return longint'(a) * longint'(b);
  endfunction

  function automatic bit too_wide(longint v);
    return (v > (longint'(1) <<< 30) - 1) || (v < -(longint'(1) <<< 30));
  endfunction

  function automatic logic [31:0] bscale(longint v, logic [1:0] sh, bit rd);
    longint r;
    logic [63:0] bits;
    case (sh)
      2'b11:   r = v * 2;
      2'b01:   r = v >>> 1;
      2'b10:   r = v >>> 2;
      default: r = v;
    endcase
    bits = r;
    if (rd) bits[15] = 1'b1;
    return bits[31:0];
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic compare_outputs();
    logic [31:0] exp;
    for (int s = 0; s < 4; s++) begin
      out_sel = s[1:0];
      #1;
      case (s)
        0: exp = {m_re[31:16], m_im[31:16]};
        1: exp = {m_re[15:0],  m_im[15:0]};
        2: exp = m_re;
        default: exp = m_im;
      endcase
      chk($sformatf("%s|R8 osel=%0d", t3, s), {pr, pi}, exp);
    end
    chk($sformatf("%s|R6 ovf", t3), {31'd0, ovf}, {31'd0, m_ovf});
  endtask

  task automatic run_op(int a_r, int a_i, int b_r, int b_i, bit lx_n, bit ly_n,
                        bit cx, bit cy, logic [1:0] sh, bit rd, string tag);
    @(negedge clk);
    compare_outputs();
    xr = a_r[W-1:0]; xi = a_i[W-1:0]; yr = b_r[W-1:0]; yi = b_i[W-1:0];
    x_ld_n = lx_n; y_ld_n = ly_n; x_conj = cx; y_conj = cy;
    shift_code = sh; round_en = rd;
    @(posedge clk);
    // result stage from product stage
    begin
      longint vre, vim;
      vre = m_rr - m_ii;
      vim = m_ri + m_ir;
      m_re  = bscale(vre, m_sh2, m_rd2);
      m_im  = bscale(vim, m_sh2, m_rd2);
      m_ovf = (m_sh2 == 2'b11) && (too_wide(vre) || too_wide(vim));
    end
    // product stage from input registers (R2, R3, R4)
    m_rr = fmul(m_xr, m_yr);
    m_ri = fmul(m_xr, m_yi) * (m_cy ? -1 : 1);
    m_ir = fmul(m_xi, m_yr) * (m_cx ? -1 : 1);
    m_ii = fmul(m_xi, m_yi) * (m_cx ? -1 : 1) * (m_cy ? -1 : 1);
    m_sh2 = m_sh1; m_rd2 = m_rd1;
    m_sh1 = sh;    m_rd1 = rd;
    if (!lx_n) begin m_xr = a_r; m_xi = a_i; m_cx = cx; end
    if (!ly_n) begin m_yr = b_r; m_yi = b_i; m_cy = cy; end
    t3 = t2; t2 = t1; t1 = tag;
  endtask

  function automatic int pick_val();
    int unsigned r;
    r = $urandom % 10;
    if (r == 0) return -32768;
    if (r == 1) return 32767;
    return int'($signed(16'($urandom)));
  endfunction

  initial begin
    int unsigned seed_set;
    seed_set = $urandom(32'd20250611);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R10: reset state is checked by the first compares
    run_op(-32768, -32768, -32768, -32768, 0, 0, 0, 0, 2'b00, 0, "R3");
    run_op(-32768, 0, -32768, 0, 0, 0, 0, 0, 2'b11, 0, "R3");
    run_op(-32768, -32768, -32768, 32767, 0, 0, 0, 0, 2'b11, 0, "R6");
    run_op(-32768, -32768, -32768, 32767, 0, 0, 0, 0, 2'b00, 0, "R2");
    run_op(1000, 2000, 3000, -4000, 0, 0, 1, 0, 2'b00, 0, "R4");
    run_op(1000, 2000, 3000, -4000, 0, 0, 0, 1, 2'b00, 0, "R4");
    run_op(-32768, -32768, -32768, -32768, 0, 0, 1, 0, 2'b00, 0, "R4");
    run_op(-12345, 23456, 30000, -31000, 0, 0, 0, 0, 2'b01, 0, "R5");
    run_op(-12345, 23456, 30000, -31000, 0, 0, 0, 0, 2'b10, 0, "R5");
    run_op(-12345, 2345, 3000, -3100, 0, 0, 0, 0, 2'b11, 0, "R5");
    run_op(7, -3, 5, 9, 0, 0, 0, 0, 2'b00, 1, "R7");
    run_op(-7, 3, -5, 9, 0, 0, 0, 0, 2'b01, 1, "R7");
    run_op(100, 200, 300, 400, 0, 0, 0, 0, 2'b00, 0, "R1");
    run_op(-5, -7, 11, 13, 1, 0, 1, 0, 2'b00, 0, "R1");
    run_op(-9, -9, 17, 19, 0, 1, 0, 1, 2'b00, 0, "R1");
    for (int n = 0; n < 3000; n++) begin
      int unsigned cj;
      cj = $urandom % 3;
      run_op(pick_val(), pick_val(), pick_val(), pick_val(),
             ($urandom % 5) == 0, ($urandom % 5) == 0,
             cj == 1, cj == 2, 2'($urandom), ($urandom % 4) == 0, "R9");
    end
    repeat (3) run_op(0, 0, 0, 0, 0, 0, 0, 0, 2'b00, 0, "R9");
    @(negedge clk);
    compare_outputs();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule